// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

A synchronous single-port word memory that a controller drives through a two-token handshake. The controller owns a request token (`req_tok`) and also drives the write enable, the address and the write data. The memory owns an acknowledge token (`ack_tok`) and the registered read data (`d_out`). A request is outstanding whenever the two tokens differ. The controller raises a new request by giving `req_tok` any value other than the current `ack_tok`, for example by toggling or incrementing it. It then holds the address, the data and the write enable until `ack_tok` matches again.

For each outstanding request the memory serves exactly one access on the next clock edge. It writes when the write enable is nonzero and reads into `d_out` when the write enable is zero. In the same edge it copies `req_tok` into `ack_tok`, which closes the handshake. The address is used directly as the word index. Addresses at or beyond the configured depth are still acknowledged, but they store nothing and read back as zero. The storage has no reset, so it can map onto block RAM. Only the tokens and `d_out` are reset.

Top module: `tgl_ram`

## Requirements
- R1: While `ack_tok` equals `req_tok` (all TOKEN_W bits compared), the memory is idle. `ack_tok`, `d_out` and every stored word keep their values whatever `wr_en`, `addr` and `d_in` carry.
- R2: A request is outstanding exactly when `ack_tok` and `req_tok` differ in any bit, including only the most significant bit.
- R3: On an outstanding request with `wr_en` nonzero (any bit set, not only bit 0) and `addr` below DEPTH, `d_in` is stored at word `addr` at the next clock edge.
- R4: On an outstanding request with `wr_en` equal to zero and `addr` below DEPTH, `d_out` shows word `addr` from the next clock edge on.
- R5: At the clock edge that serves a request, `ack_tok` takes the value `req_tok` had before that edge. With `req_tok` held, no request is outstanding afterwards.
- R6: `d_out` keeps its last read value through idle cycles and through write requests.
- R7: While `rst` is high at a clock edge, `ack_tok` becomes TOKEN_RST (0 by default) and `d_out` becomes zero.
- R8: A request whose `addr` is at or above DEPTH is acknowledged normally. As a write it changes no word, including the word whose index equals the address's low bits. As a read it sets `d_out` to zero.
- R9: A new request can be raised in every cycle. Each one is served with one cycle of latency, so back-to-back requests complete at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_tok | input | TOKEN_W | Controller-owned request token |
| wr_en | input | WEN_W | Write enable; nonzero selects a write |
| addr | input | ADDR_W | Word index of the access |
| d_in | input | DATA_W | Write data |
| ack_tok | output | TOKEN_W | Memory-owned acknowledge token |
| d_out | output | DATA_W | Registered read data |

## Verification
On every cycle, the assertions check the following. The acknowledge token copies the request token one edge after a mismatch, and nothing moves while the tokens match. The decoded operation agrees with the token comparison. `d_out` holds during non-read cycles, and an out-of-range read clears `d_out`. Only the bench's scenarios can show that stored words are correct, because the memory contents are visible only through later reads. This covers a write with a high-order enable bit, a write ignored while idle, and an out-of-range write that must not alias onto a low word. The bench's reference model, compared on every clock, covers back-to-back streams of requests.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } tgl_op_e;

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tgl_ram_decode.sv
module tgl_ram_decode
  import tgl_ram_pkg::*;
#(
  parameter int unsigned TOKEN_W = 32,
  parameter int unsigned WEN_W   = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DEPTH   = 256,
  localparam int unsigned IDX_W  = idx_width(DEPTH)
) (
  input  logic [TOKEN_W-1:0] req_tok,
  input  logic [TOKEN_W-1:0] ack_tok,
  input  logic [WEN_W-1:0]   wr_en,
  input  logic [ADDR_W-1:0]  addr,
  output tgl_op_e            op,
  output logic               in_range,
  output logic [IDX_W-1:0]   idx
);

  localparam int unsigned CMP_W = ((ADDR_W > 32) ? ADDR_W : 32) + 1;
  localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

  logic pending;
  logic [CMP_W-1:0] addr_ext;

  assign pending  = (req_tok != ack_tok);
  assign addr_ext = {{(CMP_W-ADDR_W){1'b0}}, addr};
  assign in_range = (addr_ext < DEPTH_C);

  always_comb begin
    if (!pending)      op = OP_IDLE;
    else if (|wr_en)   op = OP_WRITE;
    else               op = OP_READ;
  end

  generate
    if (ADDR_W >= IDX_W) begin : g_idx_slice
      assign idx = addr[IDX_W-1:0];
    end else begin : g_idx_pad
      assign idx = {{(IDX_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

endmodule

// File: rtl/tgl_ram_store.sv
module tgl_ram_store
  import tgl_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  tgl_op_e           op,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage array: no reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (op == OP_WRITE && in_range) begin
      mem[idx] <= d_in;
    end
  end

  // Registered read port, updated only by read requests.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (op == OP_READ) begin
      rd_q <= in_range ? mem[idx] : '0;
    end
  end

  // R6: read data holds on any cycle that is not a read
  a_r6_dout_hold: assert property (@(posedge clk) disable iff (rst)
    (op != OP_READ) |=> $stable(rd_q));

  // R8: out-of-range read returns zero
  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ && !in_range) |=> (rd_q == '0));

endmodule

// File: rtl/tgl_ram_ack.sv
module tgl_ram_ack
  import tgl_ram_pkg::*;
#(
  parameter int unsigned TOKEN_W = 32,
  parameter logic [TOKEN_W-1:0] TOKEN_RST = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TOKEN_W-1:0] req_tok,
  input  tgl_op_e            op,
  output logic [TOKEN_W-1:0] ack_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= TOKEN_RST;
    end else if (op != OP_IDLE) begin
      ack_q <= req_tok;
    end
  end

  // R2: decoded activity matches a token mismatch, bit for bit
  a_r2_pending_match: assert property (@(posedge clk) disable iff (rst)
    (op != OP_IDLE) == (req_tok != ack_q));

endmodule

// File: rtl/tgl_ram.sv
module tgl_ram
  import tgl_ram_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned TOKEN_W = 32,
  parameter int unsigned WEN_W   = 32,
  parameter logic [TOKEN_W-1:0] TOKEN_RST = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TOKEN_W-1:0] req_tok,
  input  logic [WEN_W-1:0]   wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  d_in,
  output logic [TOKEN_W-1:0] ack_tok,
  output logic [DATA_W-1:0]  d_out
);

  localparam int unsigned IDX_W = idx_width(DEPTH);

  tgl_op_e          op;
  logic             in_range;
  logic [IDX_W-1:0] idx;

  tgl_ram_decode #(
    .TOKEN_W (TOKEN_W),
    .WEN_W   (WEN_W),
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH)
  ) u_decode (
    .req_tok  (req_tok),
    .ack_tok  (ack_tok),
    .wr_en    (wr_en),
    .addr     (addr),
    .op       (op),
    .in_range (in_range),
    .idx      (idx)
  );

  tgl_ram_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .in_range (in_range),
    .idx      (idx),
    .d_in     (d_in),
    .rd_q     (d_out)
  );

  tgl_ram_ack #(
    .TOKEN_W   (TOKEN_W),
    .TOKEN_RST (TOKEN_RST)
  ) u_ack (
    .clk     (clk),
    .rst     (rst),
    .req_tok (req_tok),
    .op      (op),
    .ack_q   (ack_tok)
  );

  // R1: matching tokens leave the visible state untouched
  a_r1_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (req_tok == ack_tok) |=> ($stable(ack_tok) && $stable(d_out)));

  // R5: a mismatch is closed by copying the request token at the next edge
  a_r5_ack_copies_req: assert property (@(posedge clk) disable iff (rst)
    (req_tok != ack_tok) |=> (ack_tok == $past(req_tok)));

endmodule

// File: tb/test_tgl_ram.sv
module test_tgl_ram;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned DEPTH   = 256;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned TOKEN_W = 32;
  localparam int unsigned WEN_W   = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [TOKEN_W-1:0] req_tok = '0;
  logic [WEN_W-1:0]   wr_en = '0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  d_in = '0;
  logic [TOKEN_W-1:0] ack_tok;
  logic [DATA_W-1:0]  d_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tgl_ram #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .ADDR_W (ADDR_W),
    .TOKEN_W (TOKEN_W), .WEN_W (WEN_W), .TOKEN_RST ('0)
  ) i_tgl_ram (
    .clk (clk), .rst (rst), .req_tok (req_tok), .wr_en (wr_en),
    .addr (addr), .d_in (d_in), .ack_tok (ack_tok), .d_out (d_out)
  );

  // Behavioural reference model
  logic [DATA_W-1:0]  m_mem [DEPTH];
  logic [TOKEN_W-1:0] m_ack  = '0;
  logic [DATA_W-1:0]  m_dout = '0;
  string              m_tag  = "R7";

  always @(posedge clk) begin
    if (rst) begin
      m_ack  = '0;
      m_dout = '0;
      m_tag  = "R7";
    end else if (req_tok != m_ack) begin
      if (wr_en != 0) begin
        if (int'(addr) < DEPTH) m_mem[addr] = d_in;
        m_tag = (int'(addr) < DEPTH) ? "R3" : "R8";
      end else begin
        m_dout = (int'(addr) < DEPTH) ? m_mem[addr] : '0;
        m_tag = (int'(addr) < DEPTH) ? "R4" : "R8";
      end
      m_ack = req_tok;
    end else begin
      m_tag = "R1";
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (ack_tok !== m_ack || d_out !== m_dout) begin
        n_bad++;
        $display("FAIL %s cycle compare: ack=%h d_out=%h expected ack=%h d_out=%h",
                 m_tag, ack_tok, d_out, m_ack, m_dout);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Raise one request from a negedge; returns at the next negedge.
  task automatic issue(input logic [TOKEN_W-1:0] tok, input logic [WEN_W-1:0] w,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    req_tok = tok;
    wr_en   = w;
    addr    = a;
    d_in    = d;
    @(negedge clk);
  endtask

  logic [TOKEN_W-1:0] tok = '0;

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 ack", ack_tok, 32'h0);
    chk("R7 d_out", d_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R3 and R5: write word 3
    tok = tok ^ 32'h1;
    issue(tok, 32'h1, 10'd3, 32'hA5A5_0003);
    chk("R5 ack after write", ack_tok, tok);

    // R1: idle with write enable and other address/data held
    issue(tok, 32'h1, 10'd3, 32'hDEAD_BEEF);
    issue(tok, 32'hFFFF_FFFF, 10'd7, 32'h1234_5678);
    chk("R1 ack idle", ack_tok, tok);
    chk("R1 d_out idle", d_out, 32'h0);

    // R4: read word 3, unchanged by the idle cycles
    tok = tok ^ 32'h1;
    issue(tok, 32'h0, 10'd3, 32'h0);
    chk("R4 read word 3", d_out, 32'hA5A5_0003);

    // R3: write with only a high enable bit; R6: d_out holds over the write
    tok = tok ^ 32'h1;
    issue(tok, 32'h0000_0100, 10'd4, 32'h0B0B_0004);
    chk("R6 d_out across write", d_out, 32'hA5A5_0003);
    issue(tok, 32'h0, 10'd0, 32'h0);
    issue(tok, 32'h0, 10'd0, 32'h0);
    chk("R6 d_out across idle", d_out, 32'hA5A5_0003);
    tok = tok ^ 32'h1;
    issue(tok, 32'h0, 10'd4, 32'h0);
    chk("R3 high-bit enable write", d_out, 32'h0B0B_0004);

    // R2: tokens differing only in the top bit
    tok = tok ^ 32'h8000_0000;
    issue(tok, 32'h0, 10'd3, 32'h0);
    chk("R2 top-bit request served", d_out, 32'hA5A5_0003);
    chk("R2 ack top bit", ack_tok, tok);

    // R8: out-of-range write aliasing onto word 3 must not land
    tok = tok + 32'd5;
    issue(tok, 32'h1, 10'(DEPTH + 3), 32'hCCCC_CCCC);
    chk("R8 oob write acknowledged", ack_tok, tok);
    tok = tok + 32'd1;
    issue(tok, 32'h0, 10'd3, 32'h0);
    chk("R8 alias word intact", d_out, 32'hA5A5_0003);
    tok = tok + 32'd1;
    issue(tok, 32'h0, 10'(DEPTH + 3), 32'h0);
    chk("R8 oob read zero", d_out, 32'h0);
    chk("R8 oob read acknowledged", ack_tok, tok);

    // R9: back-to-back writes, then back-to-back reads
    for (int i = 0; i < 8; i++) begin
      tok = tok + 32'd1;
      issue(tok, 32'h1, 10'(16 + i), 32'h5000_0000 + 32'(i * 17));
      chk("R9 back-to-back write ack", ack_tok, tok);
    end
    for (int i = 0; i < 8; i++) begin
      tok = tok + 32'd1;
      issue(tok, 32'h0, 10'(16 + i), 32'h0);
      chk("R9 back-to-back read", d_out, 32'h5000_0000 + 32'(i * 17));
    end

    // Top word of the array
    tok = tok + 32'd1;
    issue(tok, 32'h2, 10'(DEPTH - 1), 32'h7777_00FF);
    tok = tok + 32'd1;
    issue(tok, 32'h0, 10'(DEPTH - 1), 32'h0);
    chk("R4 last word", d_out, 32'h7777_00FF);

    // R7: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R7 ack after reset", ack_tok, 32'h0);
    chk("R7 d_out after reset", d_out, 32'h0);
    req_tok = '0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule